// File: doc/BRIEF.md
# Serial Bitstream Loader for an FPGA Target

This block loads a configuration image into a target FPGA over a one-bit serial link, acting as master of the whole sequence. A single start command, sampled together with the total image length in bytes, launches it. The block first pulls the target's active-low configuration request low for a timed reset period and confirms that the target acknowledges by pulling its status line low. It then releases the request, waits a settling period and waits for the target to release its status line, giving up after a timeout. Then it pulls image bytes from an upstream valid/ready stream and shifts them out bit by bit.

The serial clock is generated with programmable low and high phase lengths, so the link can run well below the target's maximum rate. Once the last byte has gone out, the block checks the target's configuration-complete line. It then issues a fixed run of trailing clock pulses and reports success with a one-cycle done pulse. Any failure parks the link, pulses an error strobe and holds an error code that tells the three failure kinds apart. The target's status inputs are synchronised inside the block. The durations are given in time units and turned into cycle counts from a clock-frequency parameter.

Top module: `ps_cfg_master`

## Requirements
- R1: After an accepted start, `cfg_req_n` goes low for at least the reset hold time: ceil(CLK_HZ x HOLD_NS / 1e9) cycles. The hold lasts no longer than that by more than a few cycles.
- R2: If `tgt_stat_n` is not low at the end of the reset hold, the run aborts with `err_code` = 1 and no serial clock edge is produced.
- R3: After `cfg_req_n` is released, the block waits the settle time. If `tgt_stat_n` has not gone high within a further CLK_HZ/1e6 x TIMEOUT_US cycles, the run aborts with `err_code` = 2.
- R4: Each image byte is sent as 8 bits, least significant bit first, and the bytes go out in stream order. `ser_dat` is sampled by the target on the rising edge of `ser_clk`.
- R5: Every low and every high phase of `ser_clk` lasts at least PHASE_CYC cycles, and `ser_dat` does not change while `ser_clk` is high.
- R6: If `tgt_done` is low once all bytes have been sent, the run aborts with `err_code` = 3.
- R7: After `tgt_done` is seen high, exactly PAD_CLKS (default 12) extra `ser_clk` pulses are issued before success. A failed run issues none.
- R8: On any abort, `cfg_req_n` is high, `ser_clk` is low and `busy` is low. `err` pulses for one cycle, and `err_code` holds its value until the next start. A successful run leaves `err_code` at 0.
- R9: A start asserted while `busy` is high is ignored, together with its byte count.
- R10: A byte count of zero goes straight to the completion check. Only the trailing pulses appear on `ser_clk`.
- R11: `busy` is high from the cycle after an accepted start until the run ends. On success, `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R12: `in_ready` is high only while bytes remain, the link is in its data phase and the previous byte has been fully shifted out. While it is high, `ser_clk` is low, so upstream stalls corrupt nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a configuration run (ignored while busy) |
| byte_count | input | CNT_W | Number of image bytes, sampled with start |
| in_valid | input | 1 | Upstream byte valid |
| in_data | input | 8 | Upstream image byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| cfg_req_n | output | 1 | Active-low configuration request to the target |
| ser_clk | output | 1 | Serial configuration clock |
| ser_dat | output | 1 | Serial configuration data |
| tgt_stat_n | input | 1 | Target status, active low (asynchronous) |
| tgt_done | input | 1 | Target configuration complete (asynchronous) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle abort pulse |
| err_code | output | 2 | 0 none, 1 no status acknowledge, 2 release timeout, 3 completion missing |

## Verification
The hardest cases to reach from the ports are the aborts. Each one depends on the target behaving wrongly at one exact moment of the handshake, and the release timeout also needs thousands of idle cycles. The bench therefore contains a behavioural target that can be told to ignore the reset request, never release its status, or never signal completion. It is combined with a shortened timeout, random release delays and random upstream stalls. Starts issued in the middle of a run check that they are ignored.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_SETTLE,
    ST_POLL,
    ST_SHIFT,
    ST_CHECK,
    ST_PAD
  } ld_state_t;

  typedef enum logic [1:0] {
    EC_NONE    = 2'd0,
    EC_NO_ACK  = 2'd1,
    EC_TIMEOUT = 2'd2,
    EC_NO_DONE = 2'd3
  } ld_err_t;

endpackage

// File: rtl/ps_cfg_sync.sv
module ps_cfg_sync #(
  parameter int          W       = 2,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[gi] <= RST_VAL;
          else        stg_q[gi] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[gi] <= RST_VAL;
          else        stg_q[gi] <= stg_q[gi-1];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/ps_cfg_timer.sv
module ps_cfg_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/ps_cfg_shifter.sv
module ps_cfg_shifter #(
  parameter int PHASE_CYC = 2,
  parameter int PAD_CLKS  = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       pad,
  input  logic [7:0] din,
  output logic       idle,
  output logic       sclk,
  output logic       sdat
);

  localparam int PW   = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam int NMAX = (PAD_CLKS > 8) ? PAD_CLKS : 8;
  localparam int BW   = $clog2(NMAX);
  localparam logic [PW-1:0] PH_LD  = PW'(PHASE_CYC - 1);
  localparam logic [BW-1:0] BIT_LD = BW'(7);
  localparam logic [BW-1:0] PAD_LD = BW'(PAD_CLKS - 1);

  logic          act_q, act_d;
  logic          hi_q, hi_d;
  logic          pad_q, pad_d;
  logic [PW-1:0] ph_q, ph_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [7:0]    sr_q, sr_d;
  logic          upd_en;

  assign upd_en = act_q || go;

  always_comb begin
    act_d = act_q;
    hi_d  = hi_q;
    pad_d = pad_q;
    ph_d  = ph_q;
    bit_d = bit_q;
    sr_d  = sr_q;
    if (go && !act_q) begin
      act_d = 1'b1;
      pad_d = pad;
      hi_d  = pad;
      ph_d  = PH_LD;
      bit_d = pad ? PAD_LD : BIT_LD;
      sr_d  = pad ? 8'h00 : din;
    end else if (act_q) begin
      if (ph_q != '0) begin
        ph_d = ph_q - 1'b1;
      end else begin
        ph_d = PH_LD;
        if (hi_q == pad_q) begin
          hi_d = !hi_q;
        end else if (bit_q == '0) begin
          act_d = 1'b0;
          hi_d  = 1'b0;
        end else begin
          bit_d = bit_q - 1'b1;
          sr_d  = {1'b0, sr_q[7:1]};
          hi_d  = pad_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      hi_q  <= 1'b0;
      pad_q <= 1'b0;
      ph_q  <= '0;
      bit_q <= '0;
      sr_q  <= '0;
    end else if (upd_en) begin
      act_q <= act_d;
      hi_q  <= hi_d;
      pad_q <= pad_d;
      ph_q  <= ph_d;
      bit_q <= bit_d;
      sr_q  <= sr_d;
    end
  end

  assign idle = !act_q;
  assign sclk = hi_q;
  assign sdat = sr_q[0];

  // R5: data held steady across the whole high phase
  assert_dat_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdat));

  // R12: a new transfer is only requested once the previous one is finished
  assert_go_when_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> idle);

endmodule

// File: rtl/ps_cfg_master.sv
module ps_cfg_master
  import ps_cfg_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int HOLD_NS     = 2000,
  parameter int SETTLE_NS   = 2000,
  parameter int TIMEOUT_US  = 100_000,
  parameter int PHASE_CYC   = 2,
  parameter int PAD_CLKS    = 12,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             cfg_req_n,
  output logic             ser_clk,
  output logic             ser_dat,
  input  logic             tgt_stat_n,
  input  logic             tgt_done,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [1:0]       err_code
);

  localparam longint HOLD_L   = (longint'(CLK_HZ) * longint'(HOLD_NS) + 64'd999_999_999) / 64'd1_000_000_000;
  localparam longint SETTLE_L = (longint'(CLK_HZ) * longint'(SETTLE_NS) + 64'd999_999_999) / 64'd1_000_000_000;
  localparam longint TOUT_L   = (longint'(CLK_HZ) / 64'd1_000_000) * longint'(TIMEOUT_US);
  localparam int HOLD_CYC   = (HOLD_L < 1) ? 1 : int'(HOLD_L);
  localparam int SETTLE_CYC = (SETTLE_L < 1) ? 1 : int'(SETTLE_L);
  localparam int TOUT_CYC   = (TOUT_L < 1) ? 1 : int'(TOUT_L);
  localparam int CHK_CYC    = SYNC_STAGES + 1;
  localparam int TMAX_A     = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
  localparam int TMAX_B     = (TOUT_CYC > CHK_CYC) ? TOUT_CYC : CHK_CYC;
  localparam int TMAX       = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
  localparam int TW         = $clog2(TMAX + 1);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rs_pipe_q;
  logic       rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_pipe_q <= 2'b00;
    else        rs_pipe_q <= {rs_pipe_q[0], 1'b1};
  end
  assign rs_n = rs_pipe_q[1];

  // target status synchronisers
  logic [1:0] tgt_s;
  logic       stat_n_s, done_s;
  ps_cfg_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
    .clk  (clk),
    .rst_n(rs_n),
    .d    ({tgt_done, tgt_stat_n}),
    .q    (tgt_s)
  );
  assign stat_n_s = tgt_s[0];
  assign done_s   = tgt_s[1];

  // phase timer
  logic          tmr_load, tmr_exp;
  logic [TW-1:0] tmr_val;
  ps_cfg_timer #(.W(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rs_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_exp)
  );

  // bit serializer
  logic sh_go, sh_pad, sh_idle;
  ps_cfg_shifter #(.PHASE_CYC(PHASE_CYC), .PAD_CLKS(PAD_CLKS)) u_shift (
    .clk  (clk),
    .rst_n(rs_n),
    .go   (sh_go),
    .pad  (sh_pad),
    .din  (in_data),
    .idle (sh_idle),
    .sclk (ser_clk),
    .sdat (ser_dat)
  );

  ld_state_t        st_q, st_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  ld_err_t          code_q, code_d;
  logic             err_set, done_set;
  logic             req_n_q, busy_q, done_q, err_q;

  assign in_ready = (st_q == ST_SHIFT) && sh_idle && (rem_q != '0);

  always_comb begin
    st_d     = st_q;
    rem_d    = rem_q;
    code_d   = code_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    err_set  = 1'b0;
    done_set = 1'b0;
    sh_go    = 1'b0;
    sh_pad   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d     = ST_HOLD;
          rem_d    = byte_count;
          code_d   = EC_NONE;
          tmr_load = 1'b1;
          tmr_val  = TW'(HOLD_CYC - 1);
        end
      end
      ST_HOLD: begin
        if (tmr_exp) begin
          if (!stat_n_s) begin
            st_d     = ST_SETTLE;
            tmr_load = 1'b1;
            tmr_val  = TW'(SETTLE_CYC - 1);
          end else begin
            st_d    = ST_IDLE;
            err_set = 1'b1;
            code_d  = EC_NO_ACK;
          end
        end
      end
      ST_SETTLE: begin
        if (tmr_exp) begin
          st_d     = ST_POLL;
          tmr_load = 1'b1;
          tmr_val  = TW'(TOUT_CYC - 1);
        end
      end
      ST_POLL: begin
        if (stat_n_s) begin
          st_d = ST_SHIFT;
        end else if (tmr_exp) begin
          st_d    = ST_IDLE;
          err_set = 1'b1;
          code_d  = EC_TIMEOUT;
        end
      end
      ST_SHIFT: begin
        if (sh_idle) begin
          if (rem_q == '0) begin
            st_d     = ST_CHECK;
            tmr_load = 1'b1;
            tmr_val  = TW'(CHK_CYC - 1);
          end else if (in_valid) begin
            sh_go = 1'b1;
            rem_d = rem_q - 1'b1;
          end
        end
      end
      ST_CHECK: begin
        if (tmr_exp) begin
          if (done_s) begin
            st_d   = ST_PAD;
            sh_go  = 1'b1;
            sh_pad = 1'b1;
          end else begin
            st_d    = ST_IDLE;
            err_set = 1'b1;
            code_d  = EC_NO_DONE;
          end
        end
      end
      ST_PAD: begin
        if (sh_idle) begin
          st_d     = ST_IDLE;
          done_set = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      st_q    <= ST_IDLE;
      rem_q   <= '0;
      code_q  <= EC_NONE;
      req_n_q <= 1'b1;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      rem_q   <= rem_d;
      code_q  <= code_d;
      req_n_q <= (st_d != ST_HOLD);
      busy_q  <= (st_d != ST_IDLE);
      done_q  <= done_set;
      err_q   <= err_set;
    end
  end

  assign cfg_req_n = req_n_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign err       = err_q;
  assign err_code  = code_q;

  // R1: request stays low for more than a single cycle once pulled
  assert_hold_low_R1: assert property (@(posedge clk) disable iff (!rs_n)
    $fell(cfg_req_n) |=> !cfg_req_n);

  // R2: no serial clock while the reset request is active
  assert_no_clk_in_reset_R2: assert property (@(posedge clk) disable iff (!rs_n)
    !cfg_req_n |-> !ser_clk);

  // R8: an abort leaves the link parked and reports a nonzero code
  assert_abort_park_R8: assert property (@(posedge clk) disable iff (!rs_n)
    err |-> (cfg_req_n && !ser_clk && !busy && (err_code != 2'd0)));

  // R11: done is a single-cycle pulse with busy already dropped
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rs_n)
    done |=> !done);
  assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (!rs_n)
    done |-> !busy);

  // R12: a byte is only offered while the serial clock rests low
  assert_ready_clk_low_R12: assert property (@(posedge clk) disable iff (!rs_n)
    in_ready |-> !ser_clk);

endmodule

// File: tb/tb_ps_cfg_master.sv
module tb_ps_cfg_master;

  localparam int CLK_HZ     = 100_000_000;
  localparam int TIMEOUT_US = 20;
  localparam int PHASE_CYC  = 2;
  localparam int PAD_CLKS   = 12;
  localparam int CNT_W      = 16;
  localparam int HOLD_EXP   = 200;
  localparam int SETTLE_EXP = 200;
  localparam int TOUT_EXP   = 2000;
  localparam int MAXB       = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [CNT_W-1:0] byte_count;
  logic in_valid;
  logic [7:0] in_data;
  logic in_ready, cfg_req_n, ser_clk, ser_dat, busy, done, err;
  logic [1:0] err_code;
  logic tstat_n, tdone;

  always #5 clk = ~clk;

  ps_cfg_master #(
    .CLK_HZ(CLK_HZ), .HOLD_NS(2000), .SETTLE_NS(2000), .TIMEOUT_US(TIMEOUT_US),
    .PHASE_CYC(PHASE_CYC), .PAD_CLKS(PAD_CLKS), .CNT_W(CNT_W), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .cfg_req_n(cfg_req_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .tgt_stat_n(tstat_n), .tgt_done(tdone),
    .busy(busy), .done(done), .err(err), .err_code(err_code)
  );

  int vecs = 0;
  int fails = 0;
  bit finished = 0;

  // target model settings
  bit m_stuck = 0, m_norel = 0, m_nodone = 0;
  int m_reldly = 0;
  int exp_n = 0;

  // target model state and observations
  bit released = 1;
  int rel_cnt = 0;
  logic [7:0] shreg;
  int nbits = 0, nbytes = 0;
  logic [7:0] cap [MAXB];
  logic [7:0] img [MAXB];
  int pad_edges = 0, rises = 0;
  int lo_run = 0, hold_len = 0, since_rise = 0, tmo_len = 0;
  int run_len = 0, min_hi = 1000000, min_lo = 1000000;
  int done_pulses = 0, done_cyc = 0, err_pulses = 0;
  int ready_viol = 0;
  logic [1:0] seen_code = 2'd0;
  logic cfg_prev = 1'b1, sclk_prev = 1'b0, done_prev = 1'b0, err_prev = 1'b0;

  // feeder
  int fed = 0, feed_n = 0;
  bit hs = 0;

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  initial begin
    tstat_n = 1'b1;
    tdone   = 1'b0;
    in_valid = 1'b0;
    in_data  = 8'h00;
  end

  // behavioural target and link monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (!cfg_req_n) begin
        lo_run++;
        released = 0;
        rel_cnt  = 0;
        nbits    = 0;
        nbytes   = 0;
        tstat_n  = m_stuck ? 1'b1 : 1'b0;
      end else begin
        if (!cfg_prev) begin
          hold_len   = lo_run;
          lo_run     = 0;
          since_rise = 0;
        end
        since_rise++;
        if (!released && !m_norel) begin
          if (rel_cnt >= m_reldly) released = 1;
          else rel_cnt++;
        end
        tstat_n = (released || m_stuck) ? 1'b1 : 1'b0;
      end
      if (ser_clk && !sclk_prev) begin
        rises++;
        if (tdone) pad_edges++;
        else begin
          shreg = {ser_dat, shreg[7:1]};
          nbits++;
          if (nbits == 8) begin
            if (nbytes < MAXB) cap[nbytes] = shreg;
            nbytes++;
            nbits = 0;
          end
        end
      end
      if (ser_clk == sclk_prev) run_len++;
      else begin
        if (sclk_prev) min_hi = imin(min_hi, run_len);
        else           min_lo = imin(min_lo, run_len);
        run_len = 1;
      end
      tdone = (released && cfg_req_n && !m_nodone && (nbytes >= exp_n)) ? 1'b1 : 1'b0;
      if (done) done_cyc++;
      if (done && !done_prev) done_pulses++;
      if (err && !err_prev) begin
        err_pulses++;
        seen_code = err_code;
        tmo_len   = since_rise;
      end
      if (in_ready && ser_clk) ready_viol++;
      cfg_prev  = cfg_req_n;
      sclk_prev = ser_clk;
      done_prev = done;
      err_prev  = err;
    end
  end

  // upstream byte source with random stalls
  always @(negedge clk) begin
    if (hs) fed++;
    if (fed < feed_n) begin
      in_valid = (($urandom % 4) != 0);
      in_data  = img[fed];
    end else begin
      in_valid = 1'b0;
    end
    hs = in_valid && in_ready;
  end

  task automatic run_cfg(int n, bit stuck, bit norel, bit nodone, int reldly,
                         logic [1:0] ecode, bit poke, bit directed, logic [7:0] pat);
    int waited;
    @(negedge clk);
    m_stuck = stuck; m_norel = norel; m_nodone = nodone; m_reldly = reldly;
    exp_n = n;
    for (int i = 0; i < MAXB; i++) begin
      img[i] = directed ? (pat ^ 8'(i)) : 8'($urandom);
      cap[i] = 8'hxx;
    end
    fed = 0; feed_n = n; hs = 0;
    pad_edges = 0; rises = 0; min_hi = 1000000; min_lo = 1000000;
    done_pulses = 0; done_cyc = 0; err_pulses = 0; ready_viol = 0;
    hold_len = 0; tmo_len = 0; seen_code = 2'd0;
    start = 1'b1; byte_count = CNT_W'(n);
    @(negedge clk);
    start = 1'b0; byte_count = '0;
    chk(busy === 1'b1, "R11 busy after start", int'(busy), 1);
    if (poke) begin
      repeat (300) @(negedge clk);
      start = 1'b1; byte_count = CNT_W'(n + 3);
      @(negedge clk);
      start = 1'b0; byte_count = '0;
    end
    waited = 0;
    while (busy && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    if (waited >= 20000) chk(1'b0, "R11 run did not end", waited, 20000);
    repeat (3) @(negedge clk);
    chk(cfg_req_n === 1'b1 && ser_clk === 1'b0 && busy === 1'b0, "R8 link parked",
        int'({cfg_req_n, ser_clk, busy}), 4);
    chk(hold_len >= HOLD_EXP && hold_len <= HOLD_EXP + 3, "R1 reset hold", hold_len, HOLD_EXP);
    if (ecode == 2'd0) begin
      chk(done_pulses == 1 && done_cyc == 1, "R11 done pulse", done_cyc, 1);
      chk(err_pulses == 0 && err_code == 2'd0, "R8 no error on success", err_pulses, 0);
      chk(nbytes == n, poke ? "R9 start while busy ignored" : "R4 byte count", nbytes, n);
      for (int i = 0; i < n && i < MAXB; i++)
        chk(cap[i] === img[i], "R4 LSB-first byte", int'(cap[i]), int'(img[i]));
      chk(pad_edges == PAD_CLKS, n == 0 ? "R10 only pad pulses" : "R7 pad pulses", pad_edges, PAD_CLKS);
      if (n == 0) chk(rises == PAD_CLKS, "R10 no data clocks", rises, PAD_CLKS);
      chk(min_hi >= PHASE_CYC, "R5 high phase", min_hi, PHASE_CYC);
      chk(min_lo >= PHASE_CYC, "R5 low phase", min_lo, PHASE_CYC);
      chk(ready_viol == 0, "R12 ready with clock high", ready_viol, 0);
    end else begin
      chk(err_pulses == 1 && done_pulses == 0, "R8 single error pulse", err_pulses, 1);
      chk(seen_code == ecode && err_code == ecode,
          ecode == 2'd1 ? "R2 code" : (ecode == 2'd2 ? "R3 code" : "R6 code"),
          int'(err_code), int'(ecode));
      chk(pad_edges == 0, "R7 no pad on failure", pad_edges, 0);
      if (ecode == 2'd1) chk(rises == 0, "R2 no serial clock", rises, 0);
      if (ecode == 2'd2)
        chk(tmo_len >= SETTLE_EXP + TOUT_EXP && tmo_len <= SETTLE_EXP + TOUT_EXP + 8,
            "R3 timeout length", tmo_len, SETTLE_EXP + TOUT_EXP);
    end
  endtask

  initial begin
    void'($urandom(32'h5A17C0DE));
    rst_n = 1'b0; start = 1'b0; byte_count = '0;
    repeat (4) @(negedge clk);
    chk(cfg_req_n === 1'b1 && ser_clk === 1'b0 && busy === 1'b0 && done === 1'b0
        && err === 1'b0 && in_ready === 1'b0, "R8 reset state",
        int'({cfg_req_n, ser_clk, busy, done, err, in_ready}), 32);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // directed: bit-order patterns
    run_cfg(4, 0, 0, 0, 5, 2'd0, 0, 1, 8'h01);
    run_cfg(4, 0, 0, 0, 0, 2'd0, 0, 1, 8'h80);
    run_cfg(2, 0, 0, 0, 9, 2'd0, 0, 1, 8'hFF);
    // R10: empty image
    run_cfg(0, 0, 0, 0, 3, 2'd0, 0, 0, 8'h00);
    // R2: target ignores reset request
    run_cfg(3, 1, 0, 0, 0, 2'd1, 0, 0, 8'h00);
    // R3: status never released
    run_cfg(3, 0, 1, 0, 0, 2'd2, 0, 0, 8'h00);
    // R6: completion never signalled
    run_cfg(5, 0, 0, 1, 4, 2'd3, 0, 0, 8'h00);
    // R9: start in mid-run
    run_cfg(6, 0, 0, 0, 2, 2'd0, 1, 0, 8'h00);
    // random runs
    for (int k = 0; k < 14; k++)
      run_cfg(1 + int'($urandom % MAXB), 0, 0, 0, int'($urandom % 50), 2'd0, 0, 0, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      vecs++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

endmodule